// File: doc/BRIEF.md
# Raster Fetch Timing Generator

This block produces the raster timing and the memory-fetch strobes of a tile-based video controller. A horizontal position counter runs over a 228-cycle line and a vertical counter over a 262-line frame. All strobes are decoded from that position, so each one rises and falls on a known cycle.

The line starts with 20 card fetches. Each fetch is an 8-cycle slot that carries a card strobe, an address-latch pulse and a data-read pulse. After the card fetches comes a short gap, then eight object fetches that use the same slot pattern without the card strobe. Across the frame the block raises a bus request two lines ahead of every 16-line card row. It also raises one short dummy request before the visible area, an interrupt request near the top of the bottom border, and vertical sync. It also reports which region of the frame the current line belongs to. The card sequencer, the object engine and the processor-side bus logic are driven from these outputs.

Top module: `raster_fetch_timer`

## Requirements
- R1: After reset `hPos` and `vPos` are 0. `hPos` counts up by one each clock, and the clock after 227 it returns to 0. `vPos` advances by one each time `hPos` wraps, and after line 261 it returns to 0.
- R2: `cardStb` is high only when `vPos` is at most 191, `hPos` is at most 159 and `hPos` mod 8 is 0, 1 or 2.
- R3: On every line, `addrLatch` is high when the slot sub-cycle is 1 or 2. In the card window (`hPos` 0 to 159) the sub-cycle is `hPos` mod 8. In the object window (`hPos` 162 to 225) it is (`hPos` − 162) mod 8.
- R4: On every line, `dataRead` is high when the slot sub-cycle defined in R3 is 3, 4, 5 or 6, inside either window. Sub-cycle 7 and `hPos` 160, 161, 226 and 227 carry no strobe.
- R5: `objWin` is high exactly when `hPos` is 162 to 225.
- R6: A dummy `busReq` is high from position (x=146, y=258) up to, but not including, (x=146, y=259). No `cardStb` occurs during it.
- R7: For each card row starting at line 16·k (k = 0..11), `busReq` goes high at x=227 on line 16·k − 2 (line 260 for k = 0). It stays high until it falls at x=211 on line 16·k.
- R8: The closing request rises at x=227 on line 190 and falls at x=211 on line 191. No request covers line 192.
- R9: `irq` is 0 after reset and rises at position (x=210, y=192).
- R10: `irq` goes low on the clock after `irqAck` is sampled high. When `irqAck` is high with `irq` already low, it has no effect. If the acknowledge arrives on the cycle that sets the interrupt, the set wins.
- R11: When no acknowledge arrives, `irq` goes low at position (0, 0).
- R12: `vsync` is high exactly on lines 219 to 221.
- R13: `region` encodes the line type: 0 for lines 0–191 (render), 1 for lines 192–215 (bottom border), 2 for lines 216–235 (blanking) and 3 for lines 236–261 (top border).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per pixel |
| rstN | input | 1 | Asynchronous active-low reset |
| irqAck | input | 1 | Interrupt acknowledge |
| hPos | output | 8 | Horizontal position 0..227 |
| vPos | output | 9 | Vertical line 0..261 |
| cardStb | output | 1 | Card fetch strobe |
| addrLatch | output | 1 | Fetch address latch pulse |
| dataRead | output | 1 | Fetch data read pulse |
| objWin | output | 1 | Object fetch window |
| busReq | output | 1 | Bus request to the processor side |
| irq | output | 1 | Interrupt request |
| vsync | output | 1 | Vertical sync |
| region | output | 2 | Line type code (see R13) |

## Verification
The bench watches the row-boundary requests most closely. A decoder that keyed the release on the wrong line would leave `busReq` up across line 192, or drop it a full line early at row starts. A decoder with an off-by-one would move the rise away from x=227. The object window starts at x=162, which is not a multiple of 8, so a design that took `hPos` mod 8 there would shift every object strobe by two cycles. The interrupt is tested with no acknowledge, so it must fall at line 0. It is also tested with random acknowledges and with an acknowledge on the setting cycle; a design that let the clear win would never raise `irq` on that frame.

// File: rtl/rft_pkg.sv
package rft_pkg;
  // Raster geometry
  localparam int H_TOTAL = 228;
  localparam int V_TOTAL = 262;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  // Fetch slot geometry
  localparam int SLOT_LEN  = 8;
  localparam int SUBW      = $clog2(SLOT_LEN);
  localparam int CARDS     = 20;
  localparam int OBJS      = 8;
  localparam int CARD_X0   = 0;
  localparam int OBJ_X0    = CARD_X0 + CARDS * SLOT_LEN + 2;
  localparam int NWIN      = 2;

  // Vertical layout
  localparam int RENDER_LINES = 192;
  localparam int BOTTOM_END   = 216;
  localparam int BLANK_END    = 236;
  localparam int VSYNC_FIRST  = 219;
  localparam int VSYNC_LAST   = 221;

  // Bus request schedule
  localparam int ROW_LINES   = 16;
  localparam int REQ_LEAD    = 2;
  localparam int REQ_CLR_X   = 211;
  localparam int SHORT_X     = 146;
  localparam int SHORT_LINE  = 258;

  // Interrupt
  localparam int IRQ_X    = 210;
  localparam int IRQ_LINE = RENDER_LINES;

  typedef logic [HW-1:0]   hpos_t;
  typedef logic [VW-1:0]   vpos_t;
  typedef logic [SUBW-1:0] sub_t;

  localparam hpos_t H_LAST    = hpos_t'(H_TOTAL - 1);
  localparam vpos_t V_LAST    = vpos_t'(V_TOTAL - 1);
  localparam vpos_t V_PRE_TOP = vpos_t'(V_TOTAL - REQ_LEAD);
  localparam vpos_t V_RENDER  = vpos_t'(RENDER_LINES);
  localparam vpos_t V_FINAL   = vpos_t'(RENDER_LINES - 1);
  localparam vpos_t V_BOTTOM  = vpos_t'(BOTTOM_END);
  localparam vpos_t V_BLANK   = vpos_t'(BLANK_END);
  localparam vpos_t V_VS_LO   = vpos_t'(VSYNC_FIRST);
  localparam vpos_t V_VS_HI   = vpos_t'(VSYNC_LAST);
  localparam vpos_t V_ROW     = vpos_t'(ROW_LINES);
  localparam vpos_t V_ROW_PRE = vpos_t'(ROW_LINES - REQ_LEAD);
  localparam vpos_t V_ROW_WT  = vpos_t'(ROW_LINES - 1);
  localparam hpos_t H_REQ_CLR = hpos_t'(REQ_CLR_X);
  localparam hpos_t H_SHORT   = hpos_t'(SHORT_X);
  localparam vpos_t V_SHORT   = vpos_t'(SHORT_LINE);
  localparam hpos_t H_IRQ     = hpos_t'(IRQ_X);
  localparam hpos_t H_IRQ_PRE = hpos_t'(IRQ_X - 1);
  localparam vpos_t V_IRQ     = vpos_t'(IRQ_LINE);
  localparam hpos_t H_OBJ_LO  = hpos_t'(OBJ_X0);
  localparam hpos_t H_OBJ_HI  = hpos_t'(OBJ_X0 + OBJS * SLOT_LEN - 1);
  localparam hpos_t H_CARD_HI = hpos_t'(CARD_X0 + CARDS * SLOT_LEN - 1);

  // Sub-cycle boundaries inside a slot
  localparam sub_t SUB_CARD_LAST  = sub_t'(2);
  localparam sub_t SUB_LATCH_LO   = sub_t'(1);
  localparam sub_t SUB_LATCH_HI   = sub_t'(2);
  localparam sub_t SUB_READ_LO    = sub_t'(3);
  localparam sub_t SUB_READ_HI    = sub_t'(6);

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic hWrap;
    logic vWrap;
  } cntCtl_t;

  typedef enum logic [1:0] {
    RGN_RENDER = 2'd0,
    RGN_BOTTOM = 2'd1,
    RGN_BLANK  = 2'd2,
    RGN_TOP    = 2'd3
  } region_e;
endpackage

// File: rtl/rft_counters.sv
module rft_counters
  import rft_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cntCtl_t ctl,
  output hpos_t   hPos,
  output vpos_t   vPos
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPos <= '0;
      vPos <= '0;
    end else if (ctl.hWrap) begin
      hPos <= '0;
      if (ctl.vWrap) vPos <= '0;
      else           vPos <= vPos + vpos_t'(1);
    end else begin
      hPos <= hPos + hpos_t'(1);
    end
  end
endmodule

// File: rtl/rft_fetch.sv
module rft_fetch
  import rft_pkg::*;
(
  input  hpos_t   hPos,
  input  region_e rgn,
  output logic    cardStb,
  output logic    addrLatch,
  output logic    dataRead,
  output logic    objWin
);
  logic [NWIN-1:0] inWin;
  logic [NWIN-1:0] latchHit;
  logic [NWIN-1:0] readHit;
  sub_t            sub [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int START = (w == 0) ? CARD_X0 : OBJ_X0;
    localparam int SLOTS = (w == 0) ? CARDS : OBJS;
    localparam hpos_t LO = hpos_t'(START);
    localparam hpos_t HI = hpos_t'(START + SLOTS * SLOT_LEN - 1);
    if (START == 0) begin : g_zero
      assign inWin[w] = (hPos <= HI);
    end else begin : g_off
      assign inWin[w] = (hPos >= LO) && (hPos <= HI);
    end
    assign sub[w]      = sub_t'(hPos - LO);
    assign latchHit[w] = inWin[w] && (sub[w] >= SUB_LATCH_LO) && (sub[w] <= SUB_LATCH_HI);
    assign readHit[w]  = inWin[w] && (sub[w] >= SUB_READ_LO) && (sub[w] <= SUB_READ_HI);
  end

  assign cardStb   = inWin[0] && (rgn == RGN_RENDER) && (sub[0] <= SUB_CARD_LAST);
  assign addrLatch = |latchHit;
  assign dataRead  = |readHit;
  assign objWin    = inWin[1];
endmodule

// File: rtl/rft_sched.sv
module rft_sched
  import rft_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    irqAck,
  input  hpos_t   hPos,
  input  vpos_t   vPos,
  output cntCtl_t ctl,
  output region_e rgn,
  output logic    vsync,
  output logic    busReq,
  output logic    irq
);
  vpos_t rowSub;
  logic  inRows, preLine, waitLine, startLine, finalLine;
  logic  rowReq, shortReq, irqSet, frameEnd;

  assign ctl.hWrap = (hPos == H_LAST);
  assign ctl.vWrap = (vPos == V_LAST);

  // Vertical region and sync
  always_comb begin
    if (vPos < V_RENDER)      rgn = RGN_RENDER;
    else if (vPos < V_BOTTOM) rgn = RGN_BOTTOM;
    else if (vPos < V_BLANK)  rgn = RGN_BLANK;
    else                      rgn = RGN_TOP;
  end
  assign vsync = (vPos >= V_VS_LO) && (vPos <= V_VS_HI);

  // Row requests: rise at end of the line two ahead of a row, fall mid row-start line
  assign rowSub    = vPos % V_ROW;
  assign inRows    = (vPos < V_RENDER);
  assign preLine   = (inRows && rowSub == V_ROW_PRE) || (vPos == V_PRE_TOP);
  assign waitLine  = (inRows && rowSub == V_ROW_WT) || (vPos == V_LAST);
  assign startLine = inRows && (rowSub == '0);
  assign finalLine = (vPos == V_FINAL);

  assign rowReq = (preLine && hPos == H_LAST)
                || (waitLine && !(finalLine && hPos >= H_REQ_CLR))
                || (startLine && hPos < H_REQ_CLR);

  // Dummy request spanning one full line
  assign shortReq = (vPos == V_SHORT && hPos >= H_SHORT)
                  || (vPos == V_SHORT + vpos_t'(1) && hPos < H_SHORT);

  assign busReq = rowReq || shortReq;

  // Interrupt latch: set wins over acknowledge
  assign irqSet   = (hPos == H_IRQ_PRE) && (vPos == V_IRQ);
  assign frameEnd = ctl.hWrap && ctl.vWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    irq <= 1'b0;
    else if (irqSet)              irq <= 1'b1;
    else if (irqAck || frameEnd)  irq <= 1'b0;
  end
endmodule

// File: rtl/raster_fetch_timer.sv
module raster_fetch_timer
  import rft_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          irqAck,
  output logic [HW-1:0] hPos,
  output logic [VW-1:0] vPos,
  output logic          cardStb,
  output logic          addrLatch,
  output logic          dataRead,
  output logic          objWin,
  output logic          busReq,
  output logic          irq,
  output logic          vsync,
  output logic [1:0]    region
);
  cntCtl_t ctl;
  region_e rgn;

  rft_counters u_cnt (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .hPos (hPos),
    .vPos (vPos)
  );

  rft_sched u_sched (
    .clk    (clk),
    .rstN   (rstN),
    .irqAck (irqAck),
    .hPos   (hPos),
    .vPos   (vPos),
    .ctl    (ctl),
    .rgn    (rgn),
    .vsync  (vsync),
    .busReq (busReq),
    .irq    (irq)
  );

  rft_fetch u_fetch (
    .hPos      (hPos),
    .rgn       (rgn),
    .cardStb   (cardStb),
    .addrLatch (addrLatch),
    .dataRead  (dataRead),
    .objWin    (objWin)
  );

  assign region = rgn;
endmodule

// File: rtl/rft_checker.sv
module rft_checker
  import rft_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          irqAck,
  input logic [HW-1:0] hPos,
  input logic [VW-1:0] vPos,
  input logic          cardStb,
  input logic          addrLatch,
  input logic          dataRead,
  input logic          busReq,
  input logic          irq,
  input logic          vsync
);
  // R1
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    hPos == H_LAST |=> hPos == '0);
  // R1
  h_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    hPos != H_LAST |=> hPos == $past(hPos) + hpos_t'(1));
  // R2
  card_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardStb |-> (vPos < V_RENDER) && (hPos <= H_CARD_HI));
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrLatch |-> !dataRead);
  // R6
  bus_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> (hPos == H_LAST) || (hPos == H_SHORT && vPos == V_SHORT));
  // R8
  no_req_192_chk: assert property (@(posedge clk) disable iff (!rstN)
    vPos == V_RENDER |-> !busReq);
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> hPos == H_IRQ && vPos == V_IRQ);
  // R10
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAck && irq |=> !irq);
  // R12
  vsync_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    vsync |-> (vPos >= V_VS_LO) && (vPos <= V_VS_HI));
endmodule

bind raster_fetch_timer rft_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqAck    (irqAck),
  .hPos      (hPos),
  .vPos      (vPos),
  .cardStb   (cardStb),
  .addrLatch (addrLatch),
  .dataRead  (dataRead),
  .busReq    (busReq),
  .irq       (irq),
  .vsync     (vsync)
);

// File: tb/raster_fetch_timer_test.sv
`timescale 1ns/1ps
module raster_fetch_timer_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       irqAck;
  logic [7:0] hPos;
  logic [8:0] vPos;
  logic       cardStb, addrLatch, dataRead, objWin, busReq, irq, vsync;
  logic [1:0] region;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  raster_fetch_timer uut (
    .clk(clk), .rstN(rstN), .irqAck(irqAck), .hPos(hPos), .vPos(vPos),
    .cardStb(cardStb), .addrLatch(addrLatch), .dataRead(dataRead),
    .objWin(objWin), .busReq(busReq), .irq(irq), .vsync(vsync), .region(region)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slot sub-cycle inside the card or object window, -1 outside
  function automatic int slotSub(int x);
    if (x < 160) return x % 8;
    if (x >= 162 && x <= 225) return (x - 162) % 8;
    return -1;
  endfunction

  function automatic bit expCard(int x, int y);
    return (y <= 191) && (x <= 159) && ((x % 8) <= 2);
  endfunction

  function automatic bit expLatch(int x);
    int s = slotSub(x);
    return (s == 1) || (s == 2);
  endfunction

  function automatic bit expRead(int x);
    int s = slotSub(x);
    return (s >= 3) && (s <= 6);
  endfunction

  function automatic bit expBus(int x, int y);
    bit r = 1'b0;
    if ((y == 258 && x >= 146) || (y == 259 && x < 146)) r = 1'b1;     // R6
    if ((y == 260 && x == 227) || y == 261 || (y == 0 && x < 211)) r = 1'b1; // R7
    for (int k = 1; k < 12; k++) begin                                  // R7
      if (y == 16 * k - 2 && x == 227) r = 1'b1;
      if (y == 16 * k - 1) r = 1'b1;
      if (y == 16 * k && x < 211) r = 1'b1;
    end
    if ((y == 190 && x == 227) || (y == 191 && x < 211)) r = 1'b1;     // R8
    return r;
  endfunction

  function automatic int expRegion(int y);
    if (y < 192) return 0;
    if (y < 216) return 1;
    if (y < 236) return 2;
    return 3;
  endfunction

  initial begin
    int x, y, frame;
    bit m, ack, nm;
    void'($urandom(32'd1234));
    rstN = 1'b0;
    irqAck = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(hPos == 8'd0, "R1 reset hPos", hPos, 0);
    chk(vPos == 9'd0, "R1 reset vPos", vPos, 0);
    chk(irq == 1'b0, "R9 reset irq", irq, 0);
    rstN = 1'b1;
    x = 0; y = 0; m = 1'b0; frame = 0;
    while (frame < 2) begin
      chk(hPos == x, "R1 hPos", hPos, x);
      chk(vPos == y, "R1 vPos", vPos, y);
      chk(cardStb == expCard(x, y), "R2 cardStb", cardStb, expCard(x, y));
      chk(addrLatch == expLatch(x), "R3 addrLatch", addrLatch, expLatch(x));
      chk(dataRead == expRead(x), "R4 dataRead", dataRead, expRead(x));
      chk(objWin == (x >= 162 && x <= 225), "R5 objWin", objWin, (x >= 162 && x <= 225));
      chk(busReq == expBus(x, y), "R6 R7 R8 busReq", busReq, expBus(x, y));
      chk(irq == m, "R9 R10 R11 irq", irq, m);
      chk(vsync == (y >= 219 && y <= 221), "R12 vsync", vsync, (y >= 219 && y <= 221));
      chk(region == expRegion(y), "R13 region", region, expRegion(y));
      // stimulus: frame 0 has no acknowledge (R11); frame 1 random acks plus set-cycle collision (R10)
      if (frame == 0) ack = 1'b0;
      else if (x == 209 && y == 192) ack = 1'b1;
      else ack = (($urandom % 40) == 0);
      irqAck = ack;
      if (x == 209 && y == 192) nm = 1'b1;
      else if (ack || (x == 227 && y == 261)) nm = 1'b0;
      else nm = m;
      m = nm;
      if (x == 227) begin
        x = 0;
        if (y == 261) begin y = 0; frame++; end
        else y++;
      end else x++;
      @(negedge clk);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule